// File: doc/BRIEF.md
# Data-Compare Store-Conditional Unit

This unit is the memory-side end of a store-conditional protocol in which success is decided by comparing data. The memory side keeps no reservations. A store-conditional command carries the value the requester saw at its earlier linked load, followed by the value it now wants to store. The unit reads the current word (or aligned word pair) from its internal storage and compares. On a match it stores the new data. It then sends one update or invalidate notice to each sharer of the line and holds the success answer until every notice has been acknowledged. On a mismatch it answers failure straight away and changes nothing.

The same unit also serves plain writes. A plain write is stored unconditionally. It notifies every sharer except the requester with update notices, and is answered only after all of those are acknowledged. Commands arrive as a stream of 32-bit flits. Header fields are sampled with the first flit. The storage is a two-bank register file, with even and odd words in separate banks, so that an aligned 64-bit pair is read and written in one cycle. The sharer set arrives with the command as a bitmask.

Top module: `dcsc_unit`

## Requirements
- R1: After reset, `busy`, `nt_valid` and `rsp_valid` are all 0.
- R2: A 32-bit store-conditional (`in_sc`=1, `in_wide`=0) takes two flits, the expected word then the new word. If the stored word at `in_addr` equals the expected word, the new word is stored and the response has `rsp_fail`=0.
- R3: If a store-conditional's comparison fails, nothing is stored and no notice is sent. The response has `rsp_fail`=1 and appears in the cycle after the edge that follows the last flit.
- R4: A 64-bit store-conditional (`in_wide`=1) takes four flits: expected low, expected high, new low, new high. Low is the even word of the pair and `in_addr` bit 0 is ignored. It succeeds only if both words match, and then both words are stored together.
- R5: After a successful store, one notice per cycle goes out for each set bit of the notice mask, in ascending index order, on `nt_valid`/`nt_target`. For a store-conditional the mask is `in_sharers` and `nt_inval` equals `in_inval` (1 invalidate, 0 update).
- R6: When notices were sent, the response is a one-cycle `rsp_valid` pulse. It is raised no earlier than the edge after the last notice and no earlier than the edge after the last counted `nt_ack`, whichever is later.
- R7: A plain write (`in_sc`=0) takes one flit (32-bit) or two flits (64-bit, low then high) and is always stored. Its notice mask is `in_sharers` with the requester bit `in_src` cleared, `nt_inval` is 0, and the response has `rsp_fail`=0.
- R8: `rsp_src` carries the `in_src` of the command being answered.
- R9: While `busy` is 1 after a command's flits are complete, `in_valid` flits are ignored and store nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A command flit is present |
| in_sc | input | 1 | 1 store-conditional, 0 plain write (first flit) |
| in_wide | input | 1 | 1 aligned 64-bit pair, 0 single word (first flit) |
| in_inval | input | 1 | Notice kind for a store-conditional: 1 invalidate (first flit) |
| in_addr | input | AW | Word address (first flit) |
| in_src | input | $clog2(NODES) | Requester index (first flit) |
| in_sharers | input | NODES | Sharer bitmask of the line (first flit) |
| in_data | input | 32 | Flit payload |
| busy | output | 1 | Command in progress; new first flits are not taken |
| nt_valid | output | 1 | A notice is issued this cycle |
| nt_target | output | $clog2(NODES) | Sharer index of the notice |
| nt_inval | output | 1 | 1 invalidate, 0 update |
| nt_ack | input | 1 | One notice acknowledgement |
| rsp_valid | output | 1 | Response pulse |
| rsp_fail | output | 1 | 0 success, 1 failure |
| rsp_src | output | $clog2(NODES) | Requester being answered |

## Verification
The last flit is taken at an edge counted as 0. A failure, or a success with an empty notice mask, is answered at edge 1. With N notices, the notices appear at edges 2 through N+1. If acknowledgement j is driven for edge 3+j+d, the response arrives at edge N+3+d. The bench drives inputs on falling edges and samples just after each rising edge. At every edge it compares `busy`, `nt_valid`, `nt_target`, `nt_inval`, `rsp_valid`, `rsp_fail` and `rsp_src` against a behavioural word-array model, which also predicts the expected offsets above. Stored contents are probed through later store-conditionals whose success or failure shows what the array holds.

// File: rtl/dcsc_pkg.sv
package dcsc_pkg;
  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_COLLECT = 2'd1,
    S_EXEC    = 2'd2,
    S_WAIT    = 2'd3
  } dcsc_state_t;

  localparam int FLIT_W = 32;
  localparam int MAX_FLITS = 4;
endpackage

// File: rtl/dcsc_membank.sv
module dcsc_membank #(
  parameter int DW   = 32,
  parameter int ROWS = 32,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          re,
  input  logic [RW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dcsc_notifier.sv
module dcsc_notifier #(
  parameter int NODES = 16,
  localparam int NW   = $clog2(NODES),
  localparam int CW   = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NODES-1:0] load_mask,
  input  logic             load_kind,
  input  logic             ack,
  output logic             pend_any,
  output logic [CW-1:0]    acks_left,
  output logic             nt_valid,
  output logic [NW-1:0]    nt_target,
  output logic             nt_inval
);
  logic [NODES-1:0] pend;
  logic [NW-1:0]    low_idx;
  logic [NODES-1:0] low_bit;
  logic [CW-1:0]    mask_cnt;

  always_comb begin
    low_idx = '0;
    low_bit = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        low_idx = NW'(i);
        low_bit = NODES'(1) << i;
      end
    end
  end

  always_comb begin
    mask_cnt = '0;
    for (int i = 0; i < NODES; i++) mask_cnt = mask_cnt + CW'(load_mask[i]);
  end

  assign pend_any = |pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      acks_left <= '0;
      nt_valid  <= 1'b0;
      nt_target <= '0;
      nt_inval  <= 1'b0;
    end else begin
      nt_valid <= 1'b0;
      if (load) begin
        pend      <= load_mask;
        acks_left <= mask_cnt;
        nt_inval  <= load_kind;
      end else begin
        if (pend_any) begin
          nt_valid  <= 1'b1;
          nt_target <= low_idx;
          pend      <= pend & ~low_bit;
        end
        if (ack && acks_left != '0) acks_left <= acks_left - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dcsc_unit.sv
module dcsc_unit #(
  parameter int AW    = 6,
  parameter int NODES = 16,
  localparam int NW   = $clog2(NODES),
  localparam int CW   = $clog2(NODES + 1),
  localparam int RW   = AW - 1,
  localparam int ROWS = 2 ** RW,
  localparam int DW   = dcsc_pkg::FLIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sc,
  input  logic             in_wide,
  input  logic             in_inval,
  input  logic [AW-1:0]    in_addr,
  input  logic [NW-1:0]    in_src,
  input  logic [NODES-1:0] in_sharers,
  input  logic [DW-1:0]    in_data,
  output logic             busy,
  output logic             nt_valid,
  output logic [NW-1:0]    nt_target,
  output logic             nt_inval,
  input  logic             nt_ack,
  output logic             rsp_valid,
  output logic             rsp_fail,
  output logic [NW-1:0]    rsp_src
);
  import dcsc_pkg::*;

  dcsc_state_t      state;
  logic [1:0]       fidx;
  logic [1:0]       h_last;
  logic             h_sc, h_wide, h_inval;
  logic [AW-1:0]    h_addr;
  logic [NW-1:0]    h_src;
  logic [NODES-1:0] h_sharers;
  logic [DW-1:0]    flits [MAX_FLITS];

  logic             accept;
  logic [DW-1:0]    rd   [2];
  logic [DW-1:0]    wd   [2];
  logic [1:0]       we;
  logic [DW-1:0]    exp_lo, exp_hi, new_lo, new_hi;
  logic             cmp_ok, match;
  logic [NODES-1:0] nt_mask;
  logic             nt_load;
  logic             pend_any;
  logic [CW-1:0]    acks_left;
  logic [1:0]       first_last;

  assign accept = (state == S_IDLE) && in_valid;
  assign busy   = (state != S_IDLE);
  assign first_last = in_sc ? (in_wide ? 2'd3 : 2'd1) : (in_wide ? 2'd1 : 2'd0);

  // Flit roles depend on command kind
  assign exp_lo = flits[0];
  assign exp_hi = flits[1];
  assign new_lo = h_sc ? (h_wide ? flits[2] : flits[1]) : flits[0];
  assign new_hi = h_sc ? flits[3] : flits[1];

  assign cmp_ok = h_wide ? ((rd[0] == exp_lo) && (rd[1] == exp_hi))
                         : (rd[h_addr[0]] == exp_lo);
  assign match  = !h_sc || cmp_ok;

  assign nt_mask = h_sc ? h_sharers : (h_sharers & ~(NODES'(1) << h_src));
  assign nt_load = (state == S_EXEC) && match && (nt_mask != '0);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign we[b] = (state == S_EXEC) && match && (h_wide || (h_addr[0] == 1'(b)));
    assign wd[b] = (h_wide && b == 1) ? new_hi : new_lo;
    dcsc_membank #(.DW(DW), .ROWS(ROWS)) u_bank (
      .clk   (clk),
      .re    (accept),
      .raddr (in_addr[AW-1:1]),
      .rdata (rd[b]),
      .we    (we[b]),
      .waddr (h_addr[AW-1:1]),
      .wdata (wd[b])
    );
  end

  dcsc_notifier #(.NODES(NODES)) u_ntf (
    .clk       (clk),
    .rst       (rst),
    .load      (nt_load),
    .load_mask (nt_mask),
    .load_kind (h_sc & h_inval),
    .ack       (nt_ack),
    .pend_any  (pend_any),
    .acks_left (acks_left),
    .nt_valid  (nt_valid),
    .nt_target (nt_target),
    .nt_inval  (nt_inval)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      fidx      <= '0;
      h_last    <= '0;
      h_sc      <= 1'b0;
      h_wide    <= 1'b0;
      h_inval   <= 1'b0;
      h_addr    <= '0;
      h_src     <= '0;
      h_sharers <= '0;
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_src   <= '0;
      for (int i = 0; i < MAX_FLITS; i++) flits[i] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (in_valid) begin
            h_sc      <= in_sc;
            h_wide    <= in_wide;
            h_inval   <= in_inval;
            h_addr    <= in_addr;
            h_src     <= in_src;
            h_sharers <= in_sharers;
            h_last    <= first_last;
            flits[0]  <= in_data;
            fidx      <= 2'd1;
            state     <= (first_last == 2'd0) ? S_EXEC : S_COLLECT;
          end
        end
        S_COLLECT: begin
          if (in_valid) begin
            flits[fidx] <= in_data;
            fidx        <= fidx + 2'd1;
            if (fidx == h_last) state <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (!match || nt_mask == '0) begin
            rsp_valid <= 1'b1;
            rsp_fail  <= !match;
            rsp_src   <= h_src;
            state     <= S_IDLE;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!pend_any && acks_left == '0) begin
            rsp_valid <= 1'b1;
            rsp_fail  <= 1'b0;
            rsp_src   <= h_src;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcsc_unit_sva.sv
module dcsc_unit_sva #(
  parameter int NODES = 16,
  localparam int NW   = $clog2(NODES),
  localparam int CW   = $clog2(NODES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          nt_valid,
  input logic [NW-1:0] nt_target,
  input logic          rsp_valid,
  input logic          rsp_fail,
  input logic [CW-1:0] acks_left,
  input logic          pend_any,
  input logic          h_sc
);
  p_nt_only_busy_r5: assert property (@(posedge clk) disable iff (rst)
    nt_valid |-> busy);

  p_nt_ascending_r5: assert property (@(posedge clk) disable iff (rst)
    (nt_valid && $past(nt_valid)) |-> (nt_target > $past(nt_target)));

  p_rsp_after_acks_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (acks_left == '0 && !pend_any));

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  p_write_never_fails_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !h_sc) |-> !rsp_fail);

  p_fail_no_notice_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fail) |-> !$past(nt_valid));
endmodule

bind dcsc_unit dcsc_unit_sva #(.NODES(NODES)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .nt_valid  (nt_valid),
  .nt_target (nt_target),
  .rsp_valid (rsp_valid),
  .rsp_fail  (rsp_fail),
  .acks_left (acks_left),
  .pend_any  (pend_any),
  .h_sc      (h_sc)
);

// File: tb/dcsc_unit_tb.sv
`timescale 1ns/100ps
module dcsc_unit_tb;
  localparam int AW = 6;
  localparam int NODES = 16;
  localparam int NW = $clog2(NODES);
  localparam int DEPTH = 2 ** AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sc = 1'b0, in_wide = 1'b0, in_inval = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [NW-1:0] in_src = '0;
  logic [NODES-1:0] in_sharers = '0;
  logic [31:0] in_data = '0;
  logic busy, nt_valid, nt_inval, nt_ack = 1'b0, rsp_valid, rsp_fail;
  logic [NW-1:0] nt_target, rsp_src;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] mm [DEPTH];

  always #2.5 clk = ~clk;

  dcsc_unit #(.AW(AW), .NODES(NODES)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sc(in_sc), .in_wide(in_wide),
    .in_inval(in_inval), .in_addr(in_addr), .in_src(in_src), .in_sharers(in_sharers),
    .in_data(in_data), .busy(busy), .nt_valid(nt_valid), .nt_target(nt_target),
    .nt_inval(nt_inval), .nt_ack(nt_ack), .rsp_valid(rsp_valid), .rsp_fail(rsp_fail),
    .rsp_src(rsp_src)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input string tag, input bit sc, input bit wide, input bit inval,
                        input int addr, input int src, input logic [15:0] sh,
                        input logic [31:0] d0, input logic [31:0] d1,
                        input logic [31:0] d2, input logic [31:0] d3,
                        input int dly, input bit junk);
    logic [31:0] fl [4];
    int nfl, base, n, r_rsp;
    int tl [16];
    bit ok;
    logic [15:0] mask;
    logic [31:0] nlo, nhi;
    fl[0] = d0; fl[1] = d1; fl[2] = d2; fl[3] = d3;
    nfl  = sc ? (wide ? 4 : 2) : (wide ? 2 : 1);
    base = wide ? (addr & ~1) : addr;
    if (sc) ok = wide ? (mm[base] == d0 && mm[base+1] == d1) : (mm[addr] == d0);
    else ok = 1;
    nlo = sc ? (wide ? d2 : d1) : d0;
    nhi = sc ? d3 : d1;
    if (ok) begin
      mm[base] = nlo;
      if (wide) mm[base+1] = nhi;
    end
    mask = sc ? sh : (sh & ~(16'h1 << src));
    n = 0;
    if (ok) for (int i = 0; i < 16; i++) if (mask[i]) begin tl[n] = i; n++; end
    r_rsp = (n == 0) ? 1 : n + 3 + dly;
    for (int f = 0; f < nfl; f++) begin
      @(negedge clk);
      in_valid = 1; in_sc = sc; in_wide = wide; in_inval = inval;
      in_addr = AW'(addr); in_src = NW'(src); in_sharers = sh; in_data = fl[f];
      @(posedge clk);
    end
    for (int r = 1; r <= r_rsp + 1; r++) begin
      @(negedge clk);
      in_valid = junk && (r == 2 || r == 3);
      in_sc = 0; in_wide = 0; in_addr = AW'(addr); in_data = 32'hDEAD0000 + r;
      nt_ack = (n > 0) && (r >= 3 + dly) && (r <= 2 + dly + n);
      @(posedge clk);
      #1;
      check(nt_valid == (r >= 2 && r <= n + 1), "R5", "nt_valid", nt_valid, (r >= 2 && r <= n + 1));
      if (r >= 2 && r <= n + 1) begin
        check(nt_target == NW'(tl[r-2]), "R5", "nt_target", nt_target, tl[r-2]);
        check(nt_inval == (sc & inval), sc ? "R5" : "R7", "nt_inval", nt_inval, sc & inval);
      end
      check(rsp_valid == (r == r_rsp), "R6", "rsp_valid", rsp_valid, (r == r_rsp));
      check(busy == (r < r_rsp), junk ? "R9" : "R6", "busy", busy, (r < r_rsp));
      if (r == r_rsp) begin
        check(rsp_fail == !ok, tag, "rsp_fail", rsp_fail, !ok);
        check(rsp_src == NW'(src), "R8", "rsp_src", rsp_src, src);
      end
    end
    nt_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0, "R1", "busy", busy, 0);
    check(nt_valid == 0, "R1", "nt_valid", nt_valid, 0);
    check(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    @(negedge clk); rst = 0;
    // plain writes to set up contents
    do_cmd("R7", 0, 0, 0, 4, 1, 16'h0, 32'h11, 0, 0, 0, 0, 0);
    do_cmd("R7", 0, 0, 0, 5, 2, 16'h0, 32'h22, 0, 0, 0, 0, 0);
    do_cmd("R7", 0, 1, 0, 8, 3, 16'h0, 32'hA0, 32'hA1, 0, 0, 0, 0);
    do_cmd("R7", 0, 0, 1, 6, 5, 16'h8421, 32'h66, 0, 0, 0, 0, 0);
    // narrow store-conditional success with invalidates
    do_cmd("R2", 1, 0, 1, 4, 7, 16'h0012, 32'h11, 32'h33, 0, 0, 2, 0);
    // stale expected value fails
    do_cmd("R3", 1, 0, 0, 4, 9, 16'h00F0, 32'h11, 32'h55, 0, 0, 0, 0);
    // proves the success stored and the failure did not
    do_cmd("R3", 1, 0, 0, 4, 9, 16'h0, 32'h33, 32'h44, 0, 0, 0, 0);
    do_cmd("R2", 1, 0, 0, 5, 4, 16'h0, 32'h22, 32'h23, 0, 0, 0, 0);
    // wide: high word mismatch fails, odd address bit ignored
    do_cmd("R4", 1, 1, 0, 9, 1, 16'h0003, 32'hA0, 32'hFF, 32'hC0, 32'hC1, 0, 0);
    do_cmd("R4", 1, 0, 0, 8, 1, 16'h0, 32'hA0, 32'hA0, 0, 0, 0, 0);
    do_cmd("R4", 1, 1, 0, 9, 2, 16'h0001, 32'hA0, 32'hA1, 32'hB0, 32'hB1, 0, 0);
    do_cmd("R4", 1, 0, 0, 9, 2, 16'h0, 32'hB1, 32'hB2, 0, 0, 0, 0);
    do_cmd("R4", 1, 0, 0, 8, 2, 16'h0, 32'hB0, 32'hB3, 0, 0, 0, 0);
    // wide write, requester excluded from the notice set
    do_cmd("R7", 0, 1, 0, 12, 0, 16'h8001, 32'hE0, 32'hE1, 0, 0, 1, 0);
    do_cmd("R7", 1, 1, 0, 12, 0, 16'h0, 32'hE0, 32'hE1, 32'hE2, 32'hE3, 0, 0);
    // late acknowledgements and flits during the wait
    do_cmd("R6", 1, 0, 0, 6, 3, 16'hFFFF, 32'h66, 32'h77, 0, 0, 5, 1);
    do_cmd("R9", 1, 0, 0, 6, 3, 16'h0, 32'h77, 32'h78, 0, 0, 0, 0);
    do_cmd("R9", 1, 0, 0, 6, 3, 16'h0, 32'hDEAD0002, 32'h79, 0, 0, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule